// File: doc/BRIEF.md
# CAN bit timing and synchronization unit

This block divides each bit on a CAN-style serial line into four consecutive segments. A time-quantum tick advances it through them: a one-quantum synchronization segment, a propagation segment, a first phase segment and a second phase segment. At the boundary between the two phase segments it reads the receive line. Depending on configuration, the bit value is either that single reading or a two-out-of-three vote over readings taken half a quantum apart. A baud-rate prescaler outside the block supplies both the quantum tick and a half-quantum tick. The frame logic downstream takes the sample strobe, the sampled bit and the bit-start strobe.

The block keeps its bit timing locked to the transmitting node by watching for recessive-to-dominant edges on the line. It checks for such an edge only at quantum boundaries. When the bus is idle, an edge restarts the bit outright (hard synchronization). When the bus is not idle, an edge moves the next sample point and bit boundary by a bounded amount (resynchronization). An edge that arrives late lengthens the first phase segment. An edge that arrives early shortens the second phase segment, or closes it at once.

Top module: `can_bit_timing`

## Requirements
- R1: Segment lengths come from `cfg_i`: propagation = bits [2:0]+1 and first phase = bits [5:3]+1. When bit 7 is 0, second phase = bits [10:8]+1. The synchronization segment is 1 quantum. Segments advance only on `tq_tick_i`, so an undisturbed bit lasts 1+prop+ph1+ph2 ticks.
- R2: When bit 7 of `cfg_i` is 1, the second phase length is the larger of the first phase length and 3 quanta, and bits [10:8] are ignored.
- R3: `sample_o` is a one-clock pulse in the clock after the quantum tick that closes the first phase segment. `bit_o` carries the new value in that same clock and holds it until the next pulse.
- R4: With bit 6 of `cfg_i` at 0, the sampled bit is `rx_i` at the closing quantum tick.
- R5: With bit 6 at 1, the sampled bit is the majority of three values of `rx_i`: at the closing quantum tick, at the half-quantum tick before it, and at the quantum tick before that.
- R6: `seg_o` shows the segment of the quantum in progress (0 sync, 1 propagation, 2 first phase, 3 second phase). `bit_start_o` pulses for one clock after each quantum tick that starts a synchronization quantum.
- R7: An edge is `rx_i` high at one quantum tick and low at the next. An edge seen while `bus_idle_i` is high makes the next quantum a synchronization quantum, wherever the bit was.
- R8: After a hard synchronization, no edge adjusts timing for the rest of that bit time.
- R9: With the bus not idle, an edge whose next quantum lies e quanta after the sync quantum, within the propagation or first phase segment, lengthens the first phase by min(e, sjw). Here sjw = bits [12:11]+1.
- R10: With the bus not idle, an edge whose next quantum is second-phase quantum j (0-based) behaves as follows. If ph2−j ≤ sjw, that quantum becomes a sync quantum. Otherwise the second phase is shortened by sjw.
- R11: Only the first non-idle edge in a bit time adjusts timing. An edge whose next quantum is already the sync quantum changes nothing.
- R12: After reset, `seg_o` is 0, both strobes are low and `bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_tick_i | input | 1 | One-clock pulse at each quantum boundary |
| half_tick_i | input | 1 | One-clock pulse midway through each quantum |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bus_idle_i | input | 1 | High while the frame logic sees the bus idle |
| cfg_i | input | 13 | Packed segment lengths, sampling mode, auto phase-2 and jump width |
| sample_o | output | 1 | Sample strobe |
| bit_o | output | 1 | Sampled bit value |
| bit_start_o | output | 1 | Strobe at the start of each sync quantum |
| seg_o | output | 2 | Segment of the quantum in progress |

## Verification
The hardest case to reach from the ports is an edge that arrives after a hard synchronization but within the same bit time. It has to be a second falling edge, set up by raising the line again right after the sync quantum. The bench sweeps the hard-sync point across every quantum of a bit and follows each with a non-idle edge inside the propagation segment. It checks that the sample point does not move. A similar second-edge run follows a late resynchronization. The resynchronization sweep places one edge at every quantum of a bit for each jump width, so that lengthening, shortening, and the immediate jump to sync are all reached.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  // information processing time floor for automatic phase 2
  localparam int unsigned IPT_TQ = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int unsigned FLD_W = 3,
  parameter int unsigned SJW_W = 2,
  localparam int unsigned CFG_W = 3 * FLD_W + 2 + SJW_W,
  localparam int unsigned LEN_W = FLD_W + 2
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [LEN_W-1:0] prop_len_o,
  output logic [LEN_W-1:0] ph1_len_o,
  output logic [LEN_W-1:0] ph2_len_o,
  output logic [LEN_W-1:0] sjw_len_o,
  output logic             triple_o
);
  localparam int unsigned PH1_LSB  = FLD_W;
  localparam int unsigned TRI_BIT  = 2 * FLD_W;
  localparam int unsigned AUTO_BIT = 2 * FLD_W + 1;
  localparam int unsigned PH2_LSB  = 2 * FLD_W + 2;
  localparam int unsigned SJW_LSB  = 3 * FLD_W + 2;

  logic [LEN_W-1:0] ph2_prog;

  assign prop_len_o = {{(LEN_W-FLD_W){1'b0}}, cfg_i[FLD_W-1:0]} + LEN_W'(1);
  assign ph1_len_o  = {{(LEN_W-FLD_W){1'b0}}, cfg_i[PH1_LSB +: FLD_W]} + LEN_W'(1);
  assign ph2_prog   = {{(LEN_W-FLD_W){1'b0}}, cfg_i[PH2_LSB +: FLD_W]} + LEN_W'(1);
  assign sjw_len_o  = {{(LEN_W-SJW_W){1'b0}}, cfg_i[SJW_LSB +: SJW_W]} + LEN_W'(1);
  assign triple_o   = cfg_i[TRI_BIT];

  always_comb begin
    if (cfg_i[AUTO_BIT])
      ph2_len_o = (ph1_len_o > LEN_W'(IPT_TQ)) ? ph1_len_o : LEN_W'(IPT_TQ);
    else
      ph2_len_o = ph2_prog;
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tq_tick_i,
  input  logic half_tick_i,
  input  logic rx_i,
  input  logic triple_i,
  input  logic take_i,
  output logic edge_o,
  output logic sample_o,
  output logic bit_o
);
  logic rx_tq_q, rx_half_q, vote;

  assign edge_o = tq_tick_i & rx_tq_q & ~rx_i;
  assign vote   = triple_i ? maj3(rx_tq_q, rx_half_q, rx_i) : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_tq_q   <= 1'b1;
      rx_half_q <= 1'b1;
      sample_o  <= 1'b0;
      bit_o     <= 1'b1;
    end else begin
      if (tq_tick_i)   rx_tq_q   <= rx_i;
      if (half_tick_i) rx_half_q <= rx_i;
      sample_o <= take_i;
      if (take_i) bit_o <= vote;
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_tick_i,
  input  logic             edge_i,
  input  logic             bus_idle_i,
  input  logic [LEN_W-1:0] prop_len_i,
  input  logic [LEN_W-1:0] ph1_len_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [LEN_W-1:0] sjw_len_i,
  output logic             take_o,
  output logic             bit_start_o,
  output logic [1:0]       seg_o
);
  seg_e             seg_q, seg_n;
  logic [LEN_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic [LEN_W-1:0] ext_q, ext_n, shr_q, shr_n;
  logic [LEN_W-1:0] ph1_lim, ph2_lim, off_n, rem_n;
  logic             done_q, done_n;
  logic             hard, resync;

  assign cnt_inc = cnt_q + LEN_W'(1);
  assign ph1_lim = ph1_len_i + ext_q;
  assign ph2_lim = ph2_len_i - shr_q;
  assign hard    = tq_tick_i & edge_i & bus_idle_i;
  assign resync  = tq_tick_i & edge_i & ~bus_idle_i & ~done_q;
  assign take_o  = tq_tick_i && (seg_q == SEG_PH1) && (cnt_inc >= ph1_lim);
  assign seg_o   = seg_q;

  always_comb begin
    seg_n  = seg_q;
    cnt_n  = cnt_inc;
    ext_n  = ext_q;
    shr_n  = shr_q;
    done_n = done_q;
    unique case (seg_q)
      SEG_SYNC: begin seg_n = SEG_PROP; cnt_n = '0; end
      SEG_PROP: if (cnt_inc >= prop_len_i) begin seg_n = SEG_PH1;  cnt_n = '0; end
      SEG_PH1:  if (cnt_inc >= ph1_lim)    begin seg_n = SEG_PH2;  cnt_n = '0; end
      SEG_PH2:  if (cnt_inc >= ph2_lim)    begin seg_n = SEG_SYNC; cnt_n = '0; end
      default:  begin seg_n = SEG_SYNC; cnt_n = '0; end
    endcase

    // position of the quantum about to start, in quanta after sync
    off_n = (seg_n == SEG_PROP) ? LEN_W'(1) + cnt_n : LEN_W'(1) + prop_len_i + cnt_n;
    rem_n = ph2_len_i - cnt_n;

    if (hard) begin
      seg_n = SEG_SYNC;
      cnt_n = '0;
    end else if (resync) begin
      unique case (seg_n)
        SEG_PROP, SEG_PH1: begin
          ext_n  = (off_n < sjw_len_i) ? off_n : sjw_len_i;
          done_n = 1'b1;
        end
        SEG_PH2: begin
          if (rem_n <= sjw_len_i) begin
            seg_n = SEG_SYNC;
            cnt_n = '0;
          end else begin
            shr_n  = sjw_len_i;
            done_n = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (seg_n == SEG_SYNC) begin
      ext_n  = '0;
      shr_n  = '0;
      done_n = hard;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q       <= SEG_SYNC;
      cnt_q       <= '0;
      ext_q       <= '0;
      shr_q       <= '0;
      done_q      <= 1'b0;
      bit_start_o <= 1'b0;
    end else begin
      bit_start_o <= tq_tick_i && (seg_n == SEG_SYNC);
      if (tq_tick_i) begin
        seg_q  <= seg_n;
        cnt_q  <= cnt_n;
        ext_q  <= ext_n;
        shr_q  <= shr_n;
        done_q <= done_n;
      end
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
#(
  parameter int unsigned FLD_W = 3,
  parameter int unsigned SJW_W = 2,
  localparam int unsigned CFG_W = 3 * FLD_W + 2 + SJW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_tick_i,
  input  logic             half_tick_i,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sample_o,
  output logic             bit_o,
  output logic             bit_start_o,
  output logic [1:0]       seg_o
);
  localparam int unsigned LEN_W = FLD_W + 2;

  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
  logic             triple, take, rx_edge;

  can_bt_cfg #(.FLD_W(FLD_W), .SJW_W(SJW_W)) u_cfg (
    .cfg_i      (cfg_i),
    .prop_len_o (prop_len),
    .ph1_len_o  (ph1_len),
    .ph2_len_o  (ph2_len),
    .sjw_len_o  (sjw_len),
    .triple_o   (triple)
  );

  can_bt_sampler u_smp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tq_tick_i   (tq_tick_i),
    .half_tick_i (half_tick_i),
    .rx_i        (rx_i),
    .triple_i    (triple),
    .take_i      (take),
    .edge_o      (rx_edge),
    .sample_o    (sample_o),
    .bit_o       (bit_o)
  );

  can_bt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tq_tick_i   (tq_tick_i),
    .edge_i      (rx_edge),
    .bus_idle_i  (bus_idle_i),
    .prop_len_i  (prop_len),
    .ph1_len_i   (ph1_len),
    .ph2_len_i   (ph2_len),
    .sjw_len_i   (sjw_len),
    .take_o      (take),
    .bit_start_o (bit_start_o),
    .seg_o       (seg_o)
  );
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tq_tick_i,
  input logic       bus_idle_i,
  input logic       rx_i,
  input logic       sample_o,
  input logic       bit_o,
  input logic       bit_start_o,
  input logic [1:0] seg_o
);
  logic rx_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_prev_q <= 1'b1;
    else if (tq_tick_i) rx_prev_q <= rx_i;
  end

  // R3
  sample_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(tq_tick_i));
  // R3
  sample_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  // R3
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |-> $stable(bit_o));
  // R1
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tq_tick_i |=> $stable(seg_o));
  // R6
  start_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |-> (seg_o == 2'd0) && $past(tq_tick_i));
  // R6
  sample_then_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (seg_o == 2'd3) || bit_start_o);
  // R7
  hard_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_tick_i && bus_idle_i && rx_prev_q && !rx_i) |=> bit_start_o && (seg_o == 2'd0));
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tq_tick_i   (tq_tick_i),
  .bus_idle_i  (bus_idle_i),
  .rx_i        (rx_i),
  .sample_o    (sample_o),
  .bit_o       (bit_o),
  .bit_start_o (bit_start_o),
  .seg_o       (seg_o)
);

// File: tb/sim_can_bit_timing.sv
`timescale 1ns/1ps
module sim_can_bit_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tq = 1'b0, half = 1'b0, rx = 1'b1, idle = 1'b0;
  logic [12:0] cfg = '0;
  logic        smp_o, bit_o, bst_o;
  logic [1:0]  seg_o;

  int checks = 0, errors = 0, tcount = 0;
  logic o_smp, o_bit, o_bst;
  logic [1:0] o_seg;

  always #10 clk = ~clk;

  can_bit_timing u0 (
    .clk_i(clk), .rst_ni(rst_n), .tq_tick_i(tq), .half_tick_i(half),
    .rx_i(rx), .bus_idle_i(idle), .cfg_i(cfg),
    .sample_o(smp_o), .bit_o(bit_o), .bit_start_o(bst_o), .seg_o(seg_o)
  );

  function automatic logic [12:0] mk_cfg(int p, int a, int b, bit auto_b, bit tri_b, int sjw);
    logic [12:0] c;
    c[2:0]   = 3'(p - 1);
    c[5:3]   = 3'(a - 1);
    c[6]     = tri_b;
    c[7]     = auto_b;
    c[10:8]  = 3'((b < 1 ? 1 : b) - 1);
    c[12:11] = 2'(sjw - 1);
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tq = 1'b0; half = 1'b0; rx = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tcount = 0;
  endtask

  // one quantum: rx=hv at the half tick, rx=tv at the closing quantum tick
  task automatic qt(input logic hv, input logic tv);
    @(negedge clk); rx = hv;
    @(negedge clk); half = 1'b1;
    @(negedge clk); half = 1'b0; rx = tv; tq = 1'b1;
    @(negedge clk); tq = 1'b0;
    tcount++;
    o_smp = smp_o; o_bit = bit_o; o_bst = bst_o; o_seg = seg_o;
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pv[3] = '{1, 3, 8};
    int av[4] = '{1, 2, 5, 8};
    int bv[4] = '{1, 4, 8, 0};

    // R12 reset state
    do_reset();
    @(negedge clk);
    chk("R12 seg", int'(seg_o), 0);
    chk("R12 sample", int'(smp_o), 0);
    chk("R12 bit_start", int'(bst_o), 0);
    chk("R12 bit", int'(bit_o), 1);

    // R1/R2/R3/R6 nominal timing sweep
    foreach (pv[ip]) foreach (av[ia]) foreach (bv[ib]) begin
      int p = pv[ip], a = av[ia], b = bv[ib];
      int eb, smp_t, bst_t, ph2n, sbit, sseg;
      eb = (b == 0) ? ((a > 3) ? a : 3) : b;
      cfg = mk_cfg(p, a, b, b == 0, 1'b0, 1);
      idle = 1'b0;
      do_reset();
      smp_t = -1; bst_t = -1; ph2n = 0; sbit = -1; sseg = -1;
      for (int i = 0; i < 30; i++) begin
        qt(1'b1, 1'b1);
        if (o_smp && smp_t < 0) begin smp_t = tcount; sbit = int'(o_bit); end
        if (o_bst && bst_t < 0) begin bst_t = tcount; sseg = int'(o_seg); end
        if (bst_t < 0 && o_seg == 2'd3) ph2n++;
      end
      chk("R3 sample tick", smp_t, 1 + p + a);
      chk(b == 0 ? "R2 bit length" : "R1 bit length", bst_t, 1 + p + a + eb);
      chk("R6 ph2 quanta", ph2n, eb);
      chk("R6 seg at start", sseg, 0);
      chk("R4 idle bit", sbit, 1);
    end

    // R4/R5 sampling modes over all three-value patterns, after a hard sync
    for (int tri_m = 0; tri_m < 2; tri_m++) begin
      for (int pat = 0; pat < 8; pat++) begin
        logic h2, h1, s;
        int exp_b;
        h2 = pat[2]; h1 = pat[1]; s = pat[0];
        exp_b = tri_m != 0 ? int'((h2 & h1) | (h2 & s) | (h1 & s)) : int'(s);
        cfg = mk_cfg(1, 2, 2, 1'b0, tri_m != 0, 1);
        do_reset();
        idle = 1'b1;
        qt(1'b1, 1'b0);
        chk("R7 hard sync start", int'(o_bst), 1);
        idle = 1'b0;
        qt(1'b0, 1'b0);
        qt(1'b0, 1'b0);
        qt(1'b0, h2);
        qt(h1, s);
        chk("R3 sample strobe", int'(o_smp), 1);
        chk(tri_m != 0 ? "R5 majority bit" : "R4 single bit", int'(o_bit), exp_b);
      end
    end

    // R7/R8 hard sync at every quantum, then a suppressed non-idle edge
    for (int k = 1; k <= 8; k++) begin
      int smp_t, bst_t;
      cfg = mk_cfg(2, 3, 3, 1'b0, 1'b0, 4);
      do_reset();
      idle = 1'b1;
      for (int i = 1; i < k; i++) qt(1'b1, 1'b1);
      qt(1'b1, 1'b0);
      chk("R7 bit_start on hard sync", int'(o_bst), 1);
      chk("R7 seg sync", int'(o_seg), 0);
      idle = 1'b0;
      qt(1'b0, 1'b1);
      qt(1'b1, 1'b0);
      smp_t = -1; bst_t = -1;
      for (int i = 0; i < 12; i++) begin
        qt(1'b0, 1'b0);
        if (o_smp && smp_t < 0) smp_t = tcount;
        if (o_bst && bst_t < 0) bst_t = tcount;
      end
      chk("R8 sample after hard sync", smp_t, k + 6);
      chk("R8 next bit start", bst_t, k + 9);
    end

    // R9/R10/R11 one edge at each quantum for each jump width
    for (int sjw = 1; sjw <= 4; sjw++) begin
      for (int t = 1; t <= 9; t++) begin
        int smp_t, bst_t, es, eb2;
        if (t <= 5) begin
          es  = 6 + ((t < sjw) ? t : sjw);
          eb2 = 9 + ((t < sjw) ? t : sjw);
        end else begin
          es  = 6;
          eb2 = ((9 - t) <= sjw) ? t : 9 - sjw;
        end
        cfg = mk_cfg(2, 3, 3, 1'b0, 1'b0, sjw);
        idle = 1'b0;
        do_reset();
        smp_t = -1; bst_t = -1;
        for (int i = 1; i <= 16; i++) begin
          qt(i <= t, i < t);
          if (o_smp && smp_t < 0) smp_t = tcount;
          if (o_bst && bst_t < 0) bst_t = tcount;
        end
        chk(t <= 5 ? "R9 late sample" : "R10 early sample", smp_t, es);
        chk(t <= 5 ? "R9 late bit end" : (t == 9 ? "R11 edge in sync" : "R10 early bit end"),
            bst_t, eb2);
      end
    end

    // R11 second non-idle edge in the same bit is ignored
    begin
      int smp_t;
      cfg = mk_cfg(2, 3, 3, 1'b0, 1'b0, 4);
      idle = 1'b0;
      do_reset();
      qt(1'b1, 1'b0);
      qt(1'b0, 1'b1);
      qt(1'b1, 1'b0);
      smp_t = -1;
      for (int i = 0; i < 10; i++) begin
        qt(1'b0, 1'b0);
        if (o_smp && smp_t < 0) smp_t = tcount;
      end
      chk("R11 one resync per bit", smp_t, 7);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule